// File: doc/BRIEF.md
# Four-Window Paged Memory Mapper

This block sits between a 16-bit-address processor and a 512 KB static RAM. It cuts the 64 KB logical space into four 16 KB windows. Each window owns a page register that names one 16 KB physical page. The processor reprograms the windows with I/O writes: one port picks which register is addressed, and a second port loads that register or reads it back. The physical RAM address is the chosen page number placed above the low 14 address bits.

For start-up, a boot overlay makes a reserved RAM page appear in the lowest 2 KB of logical memory. While the overlay is on, that region acts as read-only, so the boot image is protected. A dedicated I/O write turns the overlay off. An access to a second port turns it back on. The block also drives the RAM chip-select and write-enable from the processor's memory-request, refresh and write strobes.

All I/O strobes are one-clock synchronous pulses, and the I/O port number is taken from address bits 7..0. The address path is combinational, and register updates take effect at the clock edge that samples the strobe.

Top module: `page_mapper`

## Requirements
- R1: After reset, window register n holds page n (an identity map), the selected offset is 0 and the boot overlay is on.
- R2: Address bits 15..14 pick the window, and sram_addr equals {page of that window, cpu_addr[13:0]} (19 bits).
- R3: An I/O write to port F8h stores cpu_wdata[1:0] as the selected register offset, and bits 7..2 are ignored.
- R4: An I/O write to port F9h loads cpu_wdata[4:0] into the register chosen by the current offset, and leaves the other three registers unchanged.
- R5: While io_rd is high with port F9h, io_rd_hit is 1 and io_rd_data is {3'b000, selected register}. For any other port, io_rd_hit and io_rd_data are 0.
- R6: While the overlay is on, logical addresses 0000h..07FFh map to {page 31, cpu_addr[13:0]}. Addresses from 0800h up still use the window map.
- R7: While the overlay is on, sram_we_n stays high for any access to 0000h..07FFh.
- R8: An I/O write of 01h to port 38h turns the overlay off. Any other value written to port 38h has no effect.
- R9: An I/O read or an I/O write to port 39h turns the overlay on.
- R10: sram_ce_n is low only when mreq_n is low and rfsh_n is high. sram_we_n is low only when sram_ce_n is low, mem_wr_n is low and the write is not blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Processor address; bits 7..0 carry the I/O port |
| cpu_wdata | input | 8 | Processor write data for I/O writes |
| io_wr | input | 1 | One-cycle I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| mreq_n | input | 1 | Memory request, active low |
| rfsh_n | input | 1 | Refresh cycle indicator, active low |
| mem_wr_n | input | 1 | Memory write strobe, active low |
| sram_addr | output | 19 | Physical RAM address |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| io_rd_data | output | 8 | Read-back data for the page-data port |
| io_rd_hit | output | 1 | High when an I/O read targets the page-data port |

## Verification
The checker watches on every cycle that chip-select and write-enable follow the memory, refresh and write strobes, that protected overlay writes never reach the RAM, that a page-data write lands in the register named by the offset, and that the overlay port writes switch the overlay state on the following cycle. The bench scenarios show the rest. These cover the identity map after reset, the complete address translation for each window, the masking of high offset bits, read-back through the data port, the remapping of the low 2 KB, and the fact that non-01h writes to port 38h are ignored. The bench sees each of these only at the ports.

// File: rtl/page_mapper_pkg.sv
// Package: shared constants for the paged memory mapper.
// Assumes 16-bit logical addresses and 8-bit I/O ports and data.
package page_mapper_pkg;
    localparam int LOG_AW    = 16;
    localparam int WIN_OFF_W = 14;   // byte offset bits inside one window
    localparam int IO_W      = 8;
    localparam logic [IO_W-1:0] OVL_KICK_VAL = 8'h01;
endpackage

// File: rtl/map_regfile.sv
// Module: map_regfile
// Holds one page register per window plus the offset-select register.
// Assumes write strobes last one clock and are already qualified by port.
// Register n resets to page n.
module map_regfile #(
    parameter int NUM_WIN = 4,
    parameter int PAGE_W  = 5,
    localparam int WIN_W  = $clog2(NUM_WIN)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      off_we,
    input  logic [WIN_W-1:0]          off_wdata,
    input  logic                      page_we,
    input  logic [PAGE_W-1:0]         page_wdata,
    output logic [WIN_W-1:0]          offset_q,
    output logic [NUM_WIN*PAGE_W-1:0] map_flat
);
    // Offset-select register: captures which window register is addressed.
    always_ff @(posedge clk) begin
        if (!rst_n)      offset_q <= '0;
        else if (off_we) offset_q <= off_wdata;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_WIN; gi++) begin : g_win
            logic [PAGE_W-1:0] page_q;
            // Window register: identity at reset, loaded when selected.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    page_q <= PAGE_W'(gi);
                else if (page_we && (offset_q == WIN_W'(gi)))
                    page_q <= page_wdata;
            end
            assign map_flat[gi*PAGE_W +: PAGE_W] = page_q;
        end
    endgenerate
endmodule

// File: rtl/overlay_ctrl.sv
// Module: overlay_ctrl
// Tracks whether the boot overlay is active.
// Assumes port decode is done by the caller. A write of the kick value to the
// disable port clears the overlay, and any access to the restore port sets it.
module overlay_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kill_wr,
    input  logic [7:0] kill_data,
    input  logic       restore_acc,
    output logic       ovl_active
);
    import page_mapper_pkg::*;

    // Overlay state: on after reset, toggled only by the two dedicated ports.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovl_active <= 1'b1;
        else if (restore_acc)
            ovl_active <= 1'b1;
        else if (kill_wr && (kill_data == OVL_KICK_VAL))
            ovl_active <= 1'b0;
    end
endmodule

// File: rtl/addr_xlate.sv
// Module: addr_xlate
// Combinational logical-to-physical translation, RAM strobes, overlay write block.
// Assumes the overlay region sits at logical address 0 with a power-of-two size.
module addr_xlate #(
    parameter int NUM_WIN  = 4,
    parameter int PAGE_W   = 5,
    parameter int OVL_AW   = 11,
    parameter logic [PAGE_W-1:0] ROM_PAGE = '1,
    localparam int WIN_W   = $clog2(NUM_WIN),
    localparam int PHYS_AW = PAGE_W + page_mapper_pkg::WIN_OFF_W
) (
    input  logic [15:0]               cpu_addr,
    input  logic [NUM_WIN*PAGE_W-1:0] map_flat,
    input  logic                      ovl_active,
    input  logic                      mreq_n,
    input  logic                      rfsh_n,
    input  logic                      mem_wr_n,
    output logic [PHYS_AW-1:0]        sram_addr,
    output logic                      sram_ce_n,
    output logic                      sram_we_n
);
    import page_mapper_pkg::*;

    logic [WIN_W-1:0]  win_sel;
    logic [PAGE_W-1:0] win_page;
    logic              in_ovl;
    logic              mem_act;

    // Window lookup and overlay substitution.
    always_comb begin
        win_sel  = cpu_addr[LOG_AW-1 -: WIN_W];
        win_page = map_flat[win_sel*PAGE_W +: PAGE_W];
        in_ovl   = ovl_active && (cpu_addr[LOG_AW-1:OVL_AW] == '0);
        sram_addr = {(in_ovl ? ROM_PAGE : win_page), cpu_addr[WIN_OFF_W-1:0]};
    end

    // RAM strobes: select outside refresh, block writes into the protected image.
    always_comb begin
        mem_act   = !mreq_n && rfsh_n;
        sram_ce_n = !mem_act;
        sram_we_n = !(mem_act && !mem_wr_n && !in_ovl);
    end
endmodule

// File: rtl/page_mapper.sv
// Module: page_mapper (top)
// Four-window paged mapper with an I/O-programmed page table and a boot overlay.
// Assumes io_wr and io_rd are one-clock synchronous strobes, and that the
// I/O port number is cpu_addr[7:0].
module page_mapper #(
    parameter int NUM_WIN  = 4,
    parameter int PAGE_W   = 5,
    parameter int OVL_AW   = 11,
    parameter logic [PAGE_W-1:0] ROM_PAGE  = '1,
    parameter logic [7:0] OFF_PORT     = 8'hF8,
    parameter logic [7:0] DATA_PORT    = 8'hF9,
    parameter logic [7:0] OVL_OFF_PORT = 8'h38,
    parameter logic [7:0] OVL_ON_PORT  = 8'h39,
    localparam int WIN_W   = $clog2(NUM_WIN),
    localparam int PHYS_AW = PAGE_W + 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        cpu_addr,
    input  logic [7:0]         cpu_wdata,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic               mreq_n,
    input  logic               rfsh_n,
    input  logic               mem_wr_n,
    output logic [PHYS_AW-1:0] sram_addr,
    output logic               sram_ce_n,
    output logic               sram_we_n,
    output logic [7:0]         io_rd_data,
    output logic               io_rd_hit
);
    logic [7:0]                io_port;
    logic                      off_we, page_we, kill_wr, restore_acc;
    logic [WIN_W-1:0]          offset_q;
    logic [NUM_WIN*PAGE_W-1:0] map_flat;
    logic                      ovl_active;

    // Port decode for the four I/O addresses.
    always_comb begin
        io_port     = cpu_addr[7:0];
        off_we      = io_wr && (io_port == OFF_PORT);
        page_we     = io_wr && (io_port == DATA_PORT);
        kill_wr     = io_wr && (io_port == OVL_OFF_PORT);
        restore_acc = (io_wr || io_rd) && (io_port == OVL_ON_PORT);
    end

    // Read-back of the register chosen by the current offset.
    always_comb begin
        io_rd_hit  = io_rd && (io_port == DATA_PORT);
        io_rd_data = io_rd_hit ? {{(8-PAGE_W){1'b0}}, map_flat[offset_q*PAGE_W +: PAGE_W]}
                               : 8'h00;
    end

    map_regfile #(.NUM_WIN(NUM_WIN), .PAGE_W(PAGE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .off_we     (off_we),
        .off_wdata  (cpu_wdata[WIN_W-1:0]),
        .page_we    (page_we),
        .page_wdata (cpu_wdata[PAGE_W-1:0]),
        .offset_q   (offset_q),
        .map_flat   (map_flat)
    );

    overlay_ctrl u_ovl (
        .clk         (clk),
        .rst_n       (rst_n),
        .kill_wr     (kill_wr),
        .kill_data   (cpu_wdata),
        .restore_acc (restore_acc),
        .ovl_active  (ovl_active)
    );

    addr_xlate #(.NUM_WIN(NUM_WIN), .PAGE_W(PAGE_W), .OVL_AW(OVL_AW),
                 .ROM_PAGE(ROM_PAGE)) u_xlate (
        .cpu_addr   (cpu_addr),
        .map_flat   (map_flat),
        .ovl_active (ovl_active),
        .mreq_n     (mreq_n),
        .rfsh_n     (rfsh_n),
        .mem_wr_n   (mem_wr_n),
        .sram_addr  (sram_addr),
        .sram_ce_n  (sram_ce_n),
        .sram_we_n  (sram_we_n)
    );
endmodule

// File: rtl/page_mapper_chk.sv
// Module: page_mapper_chk
// Assertion checker bound to page_mapper. It observes ports and the
// register state and drives nothing.
module page_mapper_chk #(
    parameter int NUM_WIN = 4,
    parameter int PAGE_W  = 5,
    localparam int WIN_W  = $clog2(NUM_WIN)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [15:0]               cpu_addr,
    input logic [7:0]                cpu_wdata,
    input logic                      io_wr,
    input logic                      io_rd,
    input logic                      mreq_n,
    input logic                      rfsh_n,
    input logic                      mem_wr_n,
    input logic                      sram_ce_n,
    input logic                      sram_we_n,
    input logic [WIN_W-1:0]          offset_q,
    input logic [NUM_WIN*PAGE_W-1:0] map_flat,
    input logic                      ovl_active
);
    AST_CE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_n || !rfsh_n) |-> sram_ce_n);                                    // R10
    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_ce_n || mem_wr_n) |-> sram_we_n);                               // R10
    AST_OVL_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_active && cpu_addr[15:11] == 5'd0) |-> sram_we_n);              // R7
    AST_PAGE_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && cpu_addr[7:0] == 8'hF9) |=>
        (map_flat[$past(offset_q)*PAGE_W +: PAGE_W] == $past(cpu_wdata[PAGE_W-1:0]))); // R4
    AST_OFFSET_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && cpu_addr[7:0] == 8'hF8) |=> (offset_q == $past(cpu_wdata[WIN_W-1:0]))); // R3
    AST_OVL_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && cpu_addr[7:0] == 8'h38 && cpu_wdata == 8'h01) |=> !ovl_active); // R8
    AST_OVL_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_wr || io_rd) && cpu_addr[7:0] == 8'h39) |=> ovl_active);        // R9
endmodule

bind page_mapper page_mapper_chk #(.NUM_WIN(NUM_WIN), .PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .mreq_n(mreq_n), .rfsh_n(rfsh_n),
    .mem_wr_n(mem_wr_n), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .offset_q(offset_q), .map_flat(map_flat), .ovl_active(ovl_active)
);

// File: tb/page_mapper_tb.sv
// Directed bench for page_mapper: one task per scenario, using its own model.
module page_mapper_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic        mreq_n = 1'b1, rfsh_n = 1'b1, mem_wr_n = 1'b1;
    logic [18:0] sram_addr;
    logic        sram_ce_n, sram_we_n, io_rd_hit;
    logic [7:0]  io_rd_data;

    int checks = 0, failures = 0;
    logic [4:0] m_map [4];
    logic [1:0] m_off;
    logic       m_ovl;

    page_mapper u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [18:0] exp_addr(logic [15:0] a);
        if (m_ovl && a[15:11] == 5'd0) return {5'd31, a[13:0]};
        return {m_map[a[15:14]], a[13:0]};
    endfunction

    task automatic io_write(logic [7:0] port, logic [7:0] data);
        @(negedge clk);
        cpu_addr = {8'h00, port}; cpu_wdata = data; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (port == 8'hF8) m_off = data[1:0];
        if (port == 8'hF9) m_map[m_off] = data[4:0];
        if (port == 8'h38 && data == 8'h01) m_ovl = 1'b0;
        if (port == 8'h39) m_ovl = 1'b1;
    endtask

    task automatic mem_probe(string req, logic [15:0] a);
        cpu_addr = a; #1;
        chk(req, sram_addr, exp_addr(a));
    endtask

    task automatic t_reset();
        for (int w = 0; w < 4; w++) mem_probe("R1", {w[1:0], 14'h0123});
        chk("R1", u_dut.io_rd_hit, 0);
        cpu_addr = 16'h00F9; io_rd = 1'b1; #1;
        chk("R1", io_rd_data, 8'h00);
        io_rd = 1'b0;
        mem_probe("R1", 16'h0100);
    endtask

    task automatic t_translate();
        io_write(8'hF8, 8'h02); io_write(8'hF9, 8'h15);
        io_write(8'hF8, 8'h03); io_write(8'hF9, 8'h07);
        mem_probe("R2", 16'h8ABC); chk("R2", sram_addr, {5'h15, 14'h0ABC});
        mem_probe("R2", 16'hFFFF); chk("R2", sram_addr, {5'h07, 14'h3FFF});
        mem_probe("R4", 16'h4000); chk("R4", sram_addr, {5'h01, 14'h0000});
    endtask

    task automatic t_offset_mask();
        io_write(8'hF8, 8'hFD);   // upper bits ignored, offset 1
        io_write(8'hF9, 8'hE9);   // loads 5'h09
        mem_probe("R3", 16'h4567); chk("R3", sram_addr, {5'h09, 14'h0567});
        mem_probe("R4", 16'hC000);
    endtask

    task automatic t_readback();
        io_write(8'hF8, 8'h02);
        @(negedge clk); cpu_addr = 16'h00F9; io_rd = 1'b1; #1;
        chk("R5", io_rd_hit, 1); chk("R5", io_rd_data, 8'h15);
        cpu_addr = 16'h00F8; #1;
        chk("R5", io_rd_hit, 0); chk("R5", io_rd_data, 8'h00);
        io_rd = 1'b0;
    endtask

    task automatic t_overlay();
        mem_probe("R6", 16'h07FF); chk("R6", sram_addr, 19'h7C7FF);
        io_write(8'hF8, 8'h00); io_write(8'hF9, 8'h04);
        mem_probe("R6", 16'h0800); chk("R6", sram_addr, 19'h10800);
        @(negedge clk); cpu_addr = 16'h0010; mreq_n = 0; mem_wr_n = 0; #1;
        chk("R7", sram_ce_n, 0); chk("R7", sram_we_n, 1);
        cpu_addr = 16'h0800; #1;
        chk("R7", sram_we_n, 0);
        mreq_n = 1; mem_wr_n = 1;
    endtask

    task automatic t_ovl_switch();
        io_write(8'h38, 8'h02);
        mem_probe("R8", 16'h0100); chk("R8", sram_addr, 19'h7C100);
        io_write(8'h38, 8'h01);
        mem_probe("R8", 16'h0100); chk("R8", sram_addr, 19'h10100);
        @(negedge clk); cpu_addr = 16'h0039; io_rd = 1'b1;
        @(negedge clk); io_rd = 1'b0; m_ovl = 1'b1;
        mem_probe("R9", 16'h0200); chk("R9", sram_addr, 19'h7C200);
        io_write(8'h38, 8'h01); io_write(8'h39, 8'h00);
        mem_probe("R9", 16'h0300); chk("R9", sram_addr, 19'h7C300);
    endtask

    task automatic t_chipsel();
        @(negedge clk); cpu_addr = 16'h9000; mreq_n = 0; rfsh_n = 0; mem_wr_n = 0; #1;
        chk("R10", sram_ce_n, 1); chk("R10", sram_we_n, 1);
        rfsh_n = 1; #1;
        chk("R10", sram_ce_n, 0); chk("R10", sram_we_n, 0);
        mem_wr_n = 1; #1;
        chk("R10", sram_we_n, 1);
        mreq_n = 1; #1;
        chk("R10", sram_ce_n, 1);
    endtask

    initial begin
        for (int w = 0; w < 4; w++) m_map[w] = w[4:0];
        m_off = 0; m_ovl = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_translate();
        t_offset_mask();
        t_readback();
        t_overlay();
        t_ovl_switch();
        t_chipsel();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule